// File: doc/BRIEF.md
# On-Chip Trace Capture Buffer

This block records processor bus activity into a small on-chip memory so that a debug host can look at it later. Each instruction fetch taken while tracing is active becomes a one-slot execution entry. Each data bus cycle becomes a data entry that holds the address, the value, or both. A configuration field picks the content for every data cycle. Every memory slot carries a 2-bit tag that gives the entry type. An entry with both address and value takes two consecutive slots, the address first.

Tracing is gated by an active state. Trigger pulses (on, off) and host commands (start, stop) turn it on and off in real time. A single sample trigger stores one data entry from the current data cycle whether or not tracing is active. When the buffer fills, one of two modes applies. In wrap mode, writing continues over the oldest slots and a sticky flag records that this happened. In stop mode, capture freezes and the processor is not disturbed. The host sees the write pointer, a full flag and the wrap flag. It reads slots through an address/data port and can clear the buffer.

Top module: `trace_capture_buf`

## Requirements
- R1: The registered `traceActive` is set by `trigOn` or `hostStart` and cleared by `trigOff` or `hostStop`. A clear request wins over a set request in the same cycle. The new state is visible after the next clock edge and gates bus cycles from that edge on. With no request, the state holds.
- R2: While tracing is active and `cfgExecEn` is 1, each `instValid` cycle writes one slot {2'b00, instAddr} at the write pointer. With `cfgExecEn` at 0, or tracing inactive, nothing is written.
- R3: While tracing is active, a `dataValid` cycle writes by `cfgSel`:
  - 2'b01 writes one slot {2'b01, dataAddr}.
  - 2'b10 writes one slot {2'b10, dataValue}.
  - 2'b11 writes two slots, {2'b11, dataAddr} and then {2'b11, dataValue}.
  - 2'b00 writes nothing.
- R4: An instruction and a data cycle can arrive in the same clock. The instruction slot is then placed first and the data slots follow it. The write pointer advances by the number of slots written in that clock.
- R5: `trigSample` together with `dataValid` writes exactly one data entry, even while tracing is inactive. The entry uses the `cfgSel` format, and 2'b00 selects the two-slot form. When the same cycle would also be traced, it is still written only once.
- R6: With `cfgStopFull` at 0 the pointer wraps modulo DEPTH and overwrites the oldest slots. `wrapFlag` goes high on the first write past DEPTH filled slots and stays high until cleared.
- R7: With `cfgStopFull` at 1, an entry is written only if all of its slots fit. When an entry does not fit, or DEPTH slots are filled, `fullFlag` goes high. From then on nothing is written and the pointer does not move, while `traceActive` keeps its state.
- R8: `fullFlag` goes high in either mode once DEPTH slots have been filled since the last clear.
- R9: `hostClear` sets the pointer to 0 and drops `fullFlag` and `wrapFlag` after the next edge. It writes nothing in its own cycle and leaves `traceActive` unchanged.
- R10: `rdData` returns the slot at `rdAddr` one clock after `rdAddr` is presented.
- R11: After reset the pointer is 0, both flags are low and tracing is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgExecEn | input | 1 | Enables execution entries |
| cfgSel | input | 2 | Data content: bit0 address, bit1 value |
| cfgStopFull | input | 1 | 1 = freeze when full, 0 = wrap |
| instValid | input | 1 | Instruction bus cycle |
| instAddr | input | WIDTH | Instruction address |
| dataValid | input | 1 | Data bus cycle |
| dataAddr | input | WIDTH | Data address |
| dataValue | input | WIDTH | Data value |
| trigOn | input | 1 | Trigger pulse: start tracing |
| trigOff | input | 1 | Trigger pulse: stop tracing |
| trigSample | input | 1 | Trigger pulse: store one data entry |
| hostStart | input | 1 | Host command: start tracing |
| hostStop | input | 1 | Host command: stop tracing |
| hostClear | input | 1 | Host command: clear buffer |
| rdAddr | input | $clog2(DEPTH) | Host read slot |
| rdData | output | WIDTH+2 | Slot contents {tag, word} |
| wrPtr | output | $clog2(DEPTH) | Next slot to be written |
| fullFlag | output | 1 | Buffer full / frozen |
| wrapFlag | output | 1 | Oldest slots overwritten |
| traceActive | output | 1 | Tracing active state |

## Verification
Every result of this block is due exactly one clock edge after its cause. `traceActive`, `wrPtr`, `fullFlag` and `wrapFlag` settle at the edge that takes the bus cycle or command, and `rdData` settles at the edge that takes `rdAddr`. The bench drives all inputs just after a falling edge and samples the outputs at the next falling edge, so each check falls half a period after the single register stage. Slot contents are read back through the host port one clock after the address is presented. Each scenario predicts which slot each entry lands in and what the pointer and flags become.

// File: rtl/trc_pkg.sv
package trc_pkg;

  // Slot tag values; the host decodes entries by these codes
  typedef enum logic [1:0] {
    TAG_INST = 2'b00,
    TAG_ADDR = 2'b01,
    TAG_DATA = 2'b10,
    TAG_BOTH = 2'b11
  } trc_tag_e;

  // Strobes from control to datapath, one set per clock
  typedef struct packed {
    logic     clear;
    logic     instWr;
    logic     dataWr;
    trc_tag_e dataTag;
    logic     freeze;
  } trc_strobe_t;

endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgExecEn,
  input  logic [1:0]  cfgSel,
  input  logic        cfgStopFull,
  input  logic        instValid,
  input  logic        dataValid,
  input  logic        trigOn,
  input  logic        trigOff,
  input  logic        trigSample,
  input  logic        hostStart,
  input  logic        hostStop,
  input  logic        hostClear,
  input  logic [LW-1:0] level,
  input  logic        fullFlag,
  output trc_strobe_t strobe,
  output logic        traceActive
);

  logic setReq, clrReq;
  assign setReq = trigOn | hostStart;
  assign clrReq = trigOff | hostStop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       traceActive <= 1'b0;
    else if (clrReq) traceActive <= 1'b0;
    else if (setReq) traceActive <= 1'b1;
  end

  logic     instReq, dataReq;
  trc_tag_e dataKind;
  logic [LW:0] room, need;

  always_comb begin
    instReq  = traceActive & cfgExecEn & instValid;
    dataReq  = dataValid & ((traceActive & (cfgSel != 2'b00)) | trigSample);
    dataKind = (cfgSel == 2'b00) ? TAG_BOTH : trc_tag_e'(cfgSel);
    room     = (LW+1)'(DEPTH) - {1'b0, level};
    need     = (LW+1)'(instReq) + ((dataKind == TAG_BOTH) ? (LW+1)'(2) : (LW+1)'(1));

    strobe         = '0;
    strobe.dataTag = dataKind;
    if (hostClear) begin
      strobe.clear = 1'b1;
    end else if (!cfgStopFull) begin
      strobe.instWr = instReq;
      strobe.dataWr = dataReq;
    end else if (!fullFlag) begin
      strobe.instWr = instReq & (room != '0);
      strobe.dataWr = dataReq & (room >= need);
      strobe.freeze = dataReq & (room < need);
    end
  end

  AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |=> !traceActive); // R1
  AST_ON_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (setReq && !clrReq) |=> traceActive); // R1
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!setReq && !clrReq) |=> $stable(traceActive)); // R1

endmodule

// File: rtl/trc_dpath.sv
module trc_dpath
  import trc_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = PW + 1,
  localparam int EW = WIDTH + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  trc_strobe_t      strobe,
  input  logic [WIDTH-1:0] instAddr,
  input  logic [WIDTH-1:0] dataAddr,
  input  logic [WIDTH-1:0] dataValue,
  input  logic [PW-1:0]    rdAddr,
  output logic [EW-1:0]    rdData,
  output logic [PW-1:0]    wrPtr,
  output logic [LW-1:0]    level,
  output logic             fullFlag,
  output logic             wrapFlag
);

  logic [EW-1:0] mem [DEPTH];
  logic          frozen;

  // Slot positions and words for the up to three writes of one clock
  logic [PW-1:0] slotInst, slotFirst, slotSecond;
  logic [EW-1:0] wordInst, wordFirst, wordSecond;
  logic          weFirst, weSecond;
  logic [1:0]    nSlots;
  logic [LW:0]   sum;

  always_comb begin
    slotInst   = wrPtr;
    slotFirst  = wrPtr + PW'(strobe.instWr);
    slotSecond = slotFirst + PW'(1);
    wordInst   = {TAG_INST, instAddr};
    wordFirst  = {strobe.dataTag, (strobe.dataTag == TAG_DATA) ? dataValue : dataAddr};
    wordSecond = {TAG_BOTH, dataValue};
    weFirst    = strobe.dataWr;
    weSecond   = strobe.dataWr & (strobe.dataTag == TAG_BOTH);
    nSlots     = 2'(strobe.instWr) + 2'(weFirst) + 2'(weSecond);
    sum        = {1'b0, level} + (LW+1)'(nSlots);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (strobe.instWr && slotInst == PW'(i))       mem[i] <= wordInst;
      else if (weFirst && slotFirst == PW'(i))       mem[i] <= wordFirst;
      else if (weSecond && slotSecond == PW'(i))     mem[i] <= wordSecond;
    end
    rdData <= mem[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      level    <= '0;
      wrapFlag <= 1'b0;
      frozen   <= 1'b0;
    end else if (strobe.clear) begin
      wrPtr    <= '0;
      level    <= '0;
      wrapFlag <= 1'b0;
      frozen   <= 1'b0;
    end else begin
      wrPtr <= wrPtr + PW'(nSlots);
      level <= (sum > (LW+1)'(DEPTH)) ? LW'(DEPTH) : sum[LW-1:0];
      if (sum > (LW+1)'(DEPTH)) wrapFlag <= 1'b1;
      if (strobe.freeze)        frozen   <= 1'b1;
    end
  end

  assign fullFlag = frozen | (level == LW'(DEPTH));

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= LW'(DEPTH)); // R8
  AST_CLEAR_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (wrPtr == '0 && !fullFlag && !wrapFlag)); // R9
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (wrapFlag && !strobe.clear) |=> wrapFlag); // R6

endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import trc_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = PW + 1,
  localparam int EW = WIDTH + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgExecEn,
  input  logic [1:0]       cfgSel,
  input  logic             cfgStopFull,
  input  logic             instValid,
  input  logic [WIDTH-1:0] instAddr,
  input  logic             dataValid,
  input  logic [WIDTH-1:0] dataAddr,
  input  logic [WIDTH-1:0] dataValue,
  input  logic             trigOn,
  input  logic             trigOff,
  input  logic             trigSample,
  input  logic             hostStart,
  input  logic             hostStop,
  input  logic             hostClear,
  input  logic [PW-1:0]    rdAddr,
  output logic [EW-1:0]    rdData,
  output logic [PW-1:0]    wrPtr,
  output logic             fullFlag,
  output logic             wrapFlag,
  output logic             traceActive
);

  trc_strobe_t strobe;
  logic [LW-1:0] level;

  trc_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgExecEn(cfgExecEn), .cfgSel(cfgSel), .cfgStopFull(cfgStopFull),
    .instValid(instValid), .dataValid(dataValid),
    .trigOn(trigOn), .trigOff(trigOff), .trigSample(trigSample),
    .hostStart(hostStart), .hostStop(hostStop), .hostClear(hostClear),
    .level(level), .fullFlag(fullFlag),
    .strobe(strobe), .traceActive(traceActive)
  );

  trc_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .instAddr(instAddr), .dataAddr(dataAddr), .dataValue(dataValue),
    .rdAddr(rdAddr), .rdData(rdData),
    .wrPtr(wrPtr), .level(level), .fullFlag(fullFlag), .wrapFlag(wrapFlag)
  );

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStopFull && fullFlag && !hostClear) |=> $stable(wrPtr)); // R7
  AST_SAMPLE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (trigSample && dataValid && !traceActive && cfgSel == 2'b01 && !fullFlag && !hostClear)
      |=> wrPtr == $past(wrPtr) + PW'(1)); // R5
  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (!traceActive && !trigSample && !hostClear) |=> $stable(wrPtr)); // R2

endmodule

// File: tb/trace_capture_buf_tb_top.sv
`timescale 1ns/1ps
module trace_capture_buf_tb_top;

  localparam int DEPTH = 32;
  localparam int WIDTH = 16;
  localparam int PW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgExecEn = 1'b0, cfgStopFull = 1'b0;
  logic [1:0] cfgSel = 2'b00;
  logic instValid = 1'b0, dataValid = 1'b0;
  logic [WIDTH-1:0] instAddr = '0, dataAddr = '0, dataValue = '0;
  logic trigOn = 1'b0, trigOff = 1'b0, trigSample = 1'b0;
  logic hostStart = 1'b0, hostStop = 1'b0, hostClear = 1'b0;
  logic [PW-1:0] rdAddr = '0;
  logic [WIDTH+1:0] rdData;
  logic [PW-1:0] wrPtr;
  logic fullFlag, wrapFlag, traceActive;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rstN(rstN), .cfgExecEn(cfgExecEn), .cfgSel(cfgSel),
    .cfgStopFull(cfgStopFull), .instValid(instValid), .instAddr(instAddr),
    .dataValid(dataValid), .dataAddr(dataAddr), .dataValue(dataValue),
    .trigOn(trigOn), .trigOff(trigOff), .trigSample(trigSample),
    .hostStart(hostStart), .hostStop(hostStop), .hostClear(hostClear),
    .rdAddr(rdAddr), .rdData(rdData), .wrPtr(wrPtr), .fullFlag(fullFlag),
    .wrapFlag(wrapFlag), .traceActive(traceActive)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ent(input logic [1:0] tag, input logic [15:0] w);
    return {14'b0, tag, w};
  endfunction

  // One bus clock: drive after a falling edge, outputs due at the next one
  task automatic bus(input logic iv, input logic [15:0] ia, input logic dv,
                     input logic [15:0] da, input logic [15:0] dd, input logic smp);
    instValid = iv; instAddr = ia; dataValid = dv; dataAddr = da; dataValue = dd;
    trigSample = smp;
    @(negedge clk);
    instValid = 1'b0; dataValid = 1'b0; trigSample = 1'b0;
  endtask

  task automatic cmd(input logic on, input logic off, input logic st,
                     input logic sp, input logic clr);
    trigOn = on; trigOff = off; hostStart = st; hostStop = sp; hostClear = clr;
    @(negedge clk);
    trigOn = 0; trigOff = 0; hostStart = 0; hostStop = 0; hostClear = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    rdAddr = PW'(a);
    @(negedge clk);
    v = {14'b0, rdData};
  endtask

  task automatic t_reset();
    chk("R11 ptr", 32'(wrPtr), 0);
    chk("R11 full", 32'(fullFlag), 0);
    chk("R11 wrap", 32'(wrapFlag), 0);
    chk("R11 active", 32'(traceActive), 0);
  endtask

  task automatic t_enable();
    cfgExecEn = 1'b1;
    bus(1, 16'h1111, 0, 0, 0, 0);
    chk("R1 inactive ignores inst", 32'(wrPtr), 0);
    cmd(0, 0, 1, 0, 0);
    chk("R1 host start", 32'(traceActive), 1);
    cmd(1, 1, 0, 0, 0);
    chk("R1 off wins", 32'(traceActive), 0);
    bus(0, 0, 0, 0, 0, 0);
    chk("R1 holds", 32'(traceActive), 0);
    cmd(1, 0, 0, 0, 0);
    chk("R1 trigger on", 32'(traceActive), 1);
  endtask

  task automatic t_entries();
    logic [31:0] v;
    bus(1, 16'h1234, 0, 0, 0, 0);
    chk("R2 ptr", 32'(wrPtr), 1);
    cfgExecEn = 1'b0;
    bus(1, 16'h2222, 0, 0, 0, 0);
    chk("R2 exec disabled", 32'(wrPtr), 1);
    cfgSel = 2'b01; bus(0, 0, 1, 16'h00A0, 16'h00B0, 0);
    cfgSel = 2'b10; bus(0, 0, 1, 16'h00A1, 16'h00B1, 0);
    cfgSel = 2'b11; bus(0, 0, 1, 16'h00A2, 16'h00B2, 0);
    chk("R3 ptr after three", 32'(wrPtr), 5);
    cfgSel = 2'b00; bus(0, 0, 1, 16'h00A3, 16'h00B3, 0);
    chk("R3 sel none", 32'(wrPtr), 5);
    rd(0, v); chk("R2 inst slot", v, ent(2'b00, 16'h1234));
    rd(1, v); chk("R3 addr slot", v, ent(2'b01, 16'h00A0));
    rd(2, v); chk("R3 value slot", v, ent(2'b10, 16'h00B1));
    rd(3, v); chk("R3 both first", v, ent(2'b11, 16'h00A2));
    rd(4, v); chk("R3 both second", v, ent(2'b11, 16'h00B2));
  endtask

  task automatic t_order();
    logic [31:0] v;
    cfgExecEn = 1'b1; cfgSel = 2'b11;
    bus(1, 16'h3333, 1, 16'h00C0, 16'h00D0, 0);
    chk("R4 ptr plus three", 32'(wrPtr), 8);
    rd(5, v); chk("R4 inst first", v, ent(2'b00, 16'h3333));
    rd(6, v); chk("R4 addr next", v, ent(2'b11, 16'h00C0));
    rd(7, v); chk("R4 value last", v, ent(2'b11, 16'h00D0));
  endtask

  task automatic t_sample();
    logic [31:0] v;
    cmd(0, 0, 0, 1, 0);
    chk("R5 stopped", 32'(traceActive), 0);
    cfgSel = 2'b01;
    bus(1, 16'h4444, 1, 16'h00E0, 16'h00F0, 1);
    chk("R5 one entry while off", 32'(wrPtr), 9);
    cfgSel = 2'b00;
    bus(0, 0, 1, 16'h00E1, 16'h00F1, 1);
    chk("R5 sel none gives both", 32'(wrPtr), 11);
    bus(0, 0, 0, 16'h00E2, 16'h00F2, 1);
    chk("R5 no data cycle", 32'(wrPtr), 11);
    rd(8, v); chk("R5 sample slot", v, ent(2'b01, 16'h00E0));
    rd(10, v); chk("R5 both value", v, ent(2'b11, 16'h00F1));
    cmd(1, 0, 0, 0, 0);
    cfgExecEn = 1'b0; cfgSel = 2'b10;
    bus(0, 0, 1, 16'h00E3, 16'h00F3, 1);
    chk("R5 no duplicate when active", 32'(wrPtr), 12);
  endtask

  task automatic t_clear();
    cmd(0, 0, 0, 0, 1);
    chk("R9 ptr", 32'(wrPtr), 0);
    chk("R9 active kept", 32'(traceActive), 1);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    cfgExecEn = 1'b1; cfgStopFull = 1'b0;
    for (int i = 0; i < DEPTH; i++) bus(1, 16'h4000 + 16'(i), 0, 0, 0, 0);
    chk("R8 full at depth", 32'(fullFlag), 1);
    chk("R6 no wrap yet", 32'(wrapFlag), 0);
    chk("R6 ptr back to 0", 32'(wrPtr), 0);
    bus(1, 16'h5000, 0, 0, 0, 0);
    chk("R6 wrap set", 32'(wrapFlag), 1);
    chk("R6 ptr 1", 32'(wrPtr), 1);
    rd(0, v); chk("R6 oldest overwritten", v, ent(2'b00, 16'h5000));
    rd(1, v); chk("R6 next kept", v, ent(2'b00, 16'h4001));
    chk("R10 read latency", 32'(rdData), ent(2'b00, 16'h4001));
    cmd(0, 0, 0, 0, 1);
    chk("R9 flags cleared", {30'b0, fullFlag, wrapFlag}, 0);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    cfgStopFull = 1'b1; cfgSel = 2'b11;
    for (int i = 0; i < DEPTH - 1; i++) bus(1, 16'h6000 + 16'(i), 0, 0, 0, 0);
    chk("R7 not full", 32'(fullFlag), 0);
    bus(0, 0, 1, 16'h0077, 16'h0088, 0);
    chk("R7 no fit freezes", 32'(fullFlag), 1);
    chk("R7 ptr held", 32'(wrPtr), DEPTH - 1);
    bus(1, 16'h9999, 0, 0, 0, 0);
    chk("R7 blocked", 32'(wrPtr), DEPTH - 1);
    chk("R7 active kept", 32'(traceActive), 1);
    rd(DEPTH - 1, v); chk("R7 slot untouched", v, ent(2'b00, 16'h401F));
    cmd(0, 0, 0, 0, 1);
    for (int i = 0; i < DEPTH; i++) bus(1, 16'h7000 + 16'(i), 0, 0, 0, 0);
    chk("R7 full exact", 32'(fullFlag), 1);
    bus(1, 16'h7777, 0, 0, 0, 0);
    chk("R7 ptr stays", 32'(wrPtr), 0);
    chk("R7 no wrap", 32'(wrapFlag), 0);
    rd(0, v); chk("R7 first kept", v, ent(2'b00, 16'h7000));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_entries();
    t_order();
    t_sample();
    t_clear();
    t_wrap();
    t_stop();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule